// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets a processor talk to an external Ethernet PHY over the two-wire management bus (MDC clock, bidirectional MDIO data). Software programs a clock divisor and an optional preamble skip in a control register. It loads a data register when it wants to write. It then writes a command word that names the operation, the PHY address and the PHY register. The block serialises one IEEE 802.3 clause-22 frame. Software polls a busy flag, and after a read it collects the 16-bit result from the data register.

The MDIO pin is split into an output value, an output enable and an input, so the pad or the bench builds the tri-state. MDC idles low. MDC is generated only while a frame is on the wire, and it runs at the system clock divided by the programmed divisor.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Registers sit at word offsets 0 (control), 1 (command), 2 (data) and 3 (status). After reset, control reads back a divisor field of 39 (default divisor 40) in bits 16:9, with preamble skip (bit 8) and soft reset (bit 0) clear. Status and data read 0, MDC is low and MDIO is released (output enable low).
- R2: A command word launches a frame only when exactly one of bit 15 (read) and bit 14 (write) is set. Bits 9:5 give the PHY address and bits 4:0 the register number. A word with both or neither op bit set starts nothing and leaves the command readback unchanged.
- R3: Status bit 0 (busy) reads 1 from the cycle after an accepted command until the final bit period of the frame ends, then reads 0.
- R4: A command written while busy is set is ignored: no second frame follows, and the command register keeps the accepted word.
- R5: The MDC period is D system clocks, where D is the divisor field plus 1, and a field of 0 is treated as D = 2. MDC is low for floor(D/2) clocks and high for the rest. MDC stays low whenever no frame is active.
- R6: Each frame begins with 32 driven ones, unless control bit 8 is set, in which case the frame begins directly with the start pattern.
- R7: After the preamble, 32 bits follow MSB first, one per MDC period: start 01, opcode (10 read, 01 write), the 5-bit PHY address, the 5-bit register number, then for a write the turnaround 10 and the 16 data-register bits.
- R8: For a read, MDIO is released for the two turnaround bits and the 16 data bits. MDIO is sampled on each rising MDC edge of the data bits, MSB first, and the value is in the data register once busy clears.
- R9: Writing control with bit 0 set aborts any frame, clears the data register, restores control to its reset values, and reads bit 0 as 1 for 4 cycles before it clears by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe, data returned the next cycle |
| bus_addr | input | 2 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The bench sweeps divisor fields 0 through 6 (odd and even divisors, plus the clamp at 0) and also uses the default divisor 40, across read and write opcodes, with and without the preamble. Address, register and data patterns change per frame and include all-ones and all-zeros, so a swapped or shifted field, a wrong bit order or a stuck bit shows up as a mismatch at a known bit index. The MDC period and high time are measured on each edge, which separates a wrong low/high split from a wrong divisor. Further runs write a command while busy, write invalid op encodings, and issue a soft reset in mid-frame, and check through register readback and the MDC edge count that nothing else left the block.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // register word offsets
  localparam int REG_CTL = 0;
  localparam int REG_CMD = 1;
  localparam int REG_DAT = 2;
  localparam int REG_STS = 3;

  // control register fields
  localparam int CTL_SRST_BIT  = 0;
  localparam int CTL_NOPRE_BIT = 8;
  localparam int CTL_DIV_LSB   = 9;

  // command word fields
  localparam int CMD_RD_BIT  = 15;
  localparam int CMD_WR_BIT  = 14;
  localparam int CMD_PHY_LSB = 5;
  localparam int CMD_REG_LSB = 0;
  localparam int CMD_W       = 16;

  // frame geometry
  localparam int FLD_W      = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;
  localparam int TA_POS     = 14;
  localparam int DATA_POS   = 16;

  localparam logic [1:0] SOF_PAT = 2'b01;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam logic [1:0] OP_WRIT = 2'b01;
  localparam logic [1:0] TA_DRV  = 2'b10;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic [DIV_W:0] div_val,
  output logic           mdc,
  output logic           rise_tick,
  output logic           fall_tick
);
  logic [DIV_W:0] cnt;
  logic [DIV_W:0] lo_len;

  assign lo_len    = div_val >> 1;
  assign rise_tick = run && (cnt == lo_len - 1'b1);
  assign fall_tick = run && (cnt == div_val - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_tick ? '0 : cnt + 1'b1;
      if (rise_tick)      mdc <= 1'b1;
      else if (fall_tick) mdc <= 1'b0;
    end
  end

  AST_DIV_MIN: assert property (@(posedge clk) disable iff (rst)
    run |-> (div_val >= (DIV_W+1)'(2))); // R5
  AST_MDC_RISES: assert property (@(posedge clk) disable iff (rst)
    (rise_tick && run) |=> mdc); // R5
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_rd,
  input  logic [FLD_W-1:0]  phy_addr,
  input  logic [FLD_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              no_pre,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_word
);
  localparam int TOT   = PRE_BITS + FRAME_BITS;
  localparam int CNT_W = $clog2(TOT);
  localparam int FW    = $clog2(FRAME_BITS);

  logic [CNT_W-1:0]      bit_cnt;
  logic [CNT_W-1:0]      nxt_cnt;
  logic [FRAME_BITS-1:0] word_q;
  logic                  rd_q;
  logic                  nxt_in_frame;
  logic [FW-1:0]         nxt_pos;
  logic                  cur_in_frame;
  logic [FW-1:0]         cur_pos;

  assign nxt_cnt      = bit_cnt + 1'b1;
  assign nxt_in_frame = nxt_cnt[CNT_W-1];
  assign nxt_pos      = nxt_cnt[FW-1:0];
  assign cur_in_frame = bit_cnt[CNT_W-1];
  assign cur_pos      = bit_cnt[FW-1:0];
  assign done         = busy && fall_tick && (bit_cnt == CNT_W'(TOT-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bit_cnt <= '0;
      word_q  <= '0;
      rd_q    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_word <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      rd_q    <= start_rd;
      word_q  <= {SOF_PAT, (start_rd ? OP_READ : OP_WRIT), phy_addr, reg_addr, TA_DRV, wr_word};
      bit_cnt <= no_pre ? CNT_W'(PRE_BITS) : '0;
      mdio_o  <= no_pre ? SOF_PAT[1] : 1'b1;
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise_tick && rd_q && cur_in_frame && (cur_pos >= FW'(DATA_POS)))
        rd_word <= {rd_word[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (done) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          bit_cnt <= nxt_cnt;
          mdio_o  <= nxt_in_frame ? word_q[FW'(FRAME_BITS-1) - nxt_pos] : 1'b1;
          mdio_oe <= !(rd_q && nxt_in_frame && (nxt_pos >= FW'(TA_POS)));
        end
      end
    end
  end

  AST_PRE_ONES: assert property (@(posedge clk) disable iff (rst)
    (busy && !cur_in_frame) |-> (mdio_o && mdio_oe)); // R6
  AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busy && bit_cnt == CNT_W'(PRE_BITS)) |-> (!mdio_o && mdio_oe)); // R7
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q && cur_in_frame && cur_pos >= FW'(TA_POS)) |-> !mdio_oe); // R8
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int ADDR_W      = 2,
  parameter int DIV_W       = 8,
  parameter int DEF_DIV     = 40,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rdata,
  output logic              launch,
  output logic              launch_rd,
  output logic [FLD_W-1:0]  phy_addr,
  output logic [FLD_W-1:0]  reg_addr,
  output logic [DATA_W-1:0] wr_word,
  output logic              no_pre,
  output logic [DIV_W:0]    div_eff,
  output logic              srst_act
);
  localparam int SC_W = $clog2(SRST_CYCLES + 1);

  logic [DIV_W-1:0]  div_m1;
  logic [DATA_W-1:0] data_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [SC_W-1:0]   srst_cnt;
  logic              wr_ctl, wr_cmd, wr_dat;
  logic [BUS_W-1:0]  ctl_word;
  logic [BUS_W-1:0]  rd_mux;

  assign wr_ctl   = bus_we && (bus_addr == ADDR_W'(REG_CTL));
  assign wr_cmd   = bus_we && (bus_addr == ADDR_W'(REG_CMD));
  assign wr_dat   = bus_we && (bus_addr == ADDR_W'(REG_DAT));
  assign srst_act = (srst_cnt != '0);

  assign launch    = wr_cmd && !eng_busy && !srst_act &&
                     (bus_wdata[CMD_RD_BIT] ^ bus_wdata[CMD_WR_BIT]);
  assign launch_rd = bus_wdata[CMD_RD_BIT];
  assign phy_addr  = bus_wdata[CMD_PHY_LSB +: FLD_W];
  assign reg_addr  = bus_wdata[CMD_REG_LSB +: FLD_W];
  assign wr_word   = data_q;
  assign div_eff   = (div_m1 == '0) ? (DIV_W+1)'(2) : ({1'b0, div_m1} + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_m1   <= DIV_W'(DEF_DIV - 1);
      no_pre   <= 1'b0;
      data_q   <= '0;
      cmd_q    <= '0;
      srst_cnt <= '0;
    end else if (wr_ctl && bus_wdata[CTL_SRST_BIT]) begin
      div_m1   <= DIV_W'(DEF_DIV - 1);
      no_pre   <= 1'b0;
      data_q   <= '0;
      cmd_q    <= '0;
      srst_cnt <= SC_W'(SRST_CYCLES);
    end else begin
      if (srst_act) srst_cnt <= srst_cnt - 1'b1;
      if (wr_ctl && !srst_act) begin
        div_m1 <= bus_wdata[CTL_DIV_LSB +: DIV_W];
        no_pre <= bus_wdata[CTL_NOPRE_BIT];
      end
      if (launch) cmd_q <= bus_wdata[CMD_W-1:0];
      if (eng_done && !srst_act && cmd_q[CMD_RD_BIT]) data_q <= eng_rdata;
      else if (wr_dat && !eng_busy && !srst_act)     data_q <= bus_wdata[DATA_W-1:0];
    end
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_DIV_LSB +: DIV_W] = div_m1;
    ctl_word[CTL_NOPRE_BIT]        = no_pre;
    ctl_word[CTL_SRST_BIT]         = srst_act;
    case (bus_addr)
      ADDR_W'(REG_CTL): rd_mux = ctl_word;
      ADDR_W'(REG_CMD): rd_mux = BUS_W'(cmd_q);
      ADDR_W'(REG_DAT): rd_mux = BUS_W'(data_q);
      default:          rd_mux = BUS_W'(eng_busy);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && eng_busy) |=> $stable(cmd_q)); // R4
  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
    launch |=> eng_busy); // R3
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int ADDR_W      = 2,
  parameter int DIV_W       = 8,
  parameter int DEF_DIV     = 40,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic              launch, launch_rd, no_pre, srst_act;
  logic [FLD_W-1:0]  phy_addr, reg_addr;
  logic [DATA_W-1:0] wr_word, rd_word;
  logic [DIV_W:0]    div_eff;
  logic              busy, done, rise_tick, fall_tick;
  logic              core_rst;

  assign core_rst = rst || srst_act;

  mdio_csr #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W),
    .DEF_DIV(DEF_DIV), .SRST_CYCLES(SRST_CYCLES)
  ) u_csr (
    .clk(clk), .rst(rst),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(busy), .eng_done(done), .eng_rdata(rd_word),
    .launch(launch), .launch_rd(launch_rd),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_word(wr_word),
    .no_pre(no_pre), .div_eff(div_eff), .srst_act(srst_act)
  );

  mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(core_rst), .run(busy), .div_val(div_eff),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_eng u_eng (
    .clk(clk), .rst(core_rst),
    .start(launch), .start_rd(launch_rd),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_word(wr_word),
    .no_pre(no_pre), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdio_i(mdio_i), .busy(busy), .done(done),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_word(rd_word)
  );

  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc); // R5
  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    srst_act |=> !busy); // R9
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe); // R1
endmodule

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
  localparam int CLK_P  = 10;
  localparam int WD_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int tests = 0, fails = 0;
  bit finished = 0;

  // bus-model state
  logic cap_o  [0:63];
  logic cap_oe [0:63];
  int   nrise = 0;
  int   per_err = 0, hi_err = 0;
  int   exp_div = 40, pre_len = 32;
  time  t_rise = 0;
  logic [15:0] rd_val = '0;
  bit   cur_rd;
  logic [4:0] cur_phy, cur_reg;

  mdio_mgmt_ctrl uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge mdc) begin
    int f;
    if (nrise < 64) begin
      cap_o[nrise]  = mdio_o;
      cap_oe[nrise] = mdio_oe;
    end
    if (nrise > 0 && ($time - t_rise) != time'(exp_div * CLK_P)) per_err++;
    t_rise = $time;
    nrise++;
    f = nrise - 1 - pre_len;
    #1;
    if (f + 1 >= 16 && f + 1 <= 31) mdio_i = rd_val[30 - f];
    else                            mdio_i = 1'b1;
  end

  always @(negedge mdc) begin
    if (($time - t_rise) != time'((exp_div - exp_div / 2) * CLK_P)) hi_err++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic launch(input bit set_ctl, input int divf, input bit nopre, input bit rd,
                        input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] val);
    exp_div = set_ctl ? ((divf == 0) ? 2 : divf + 1) : 40;
    pre_len = nopre ? 0 : 32;
    if (set_ctl) bus_write(2'd0, (32'(divf) << 9) | (32'(nopre) << 8));
    if (!rd) bus_write(2'd2, 32'(val));
    rd_val = val; cur_rd = rd; cur_phy = phy; cur_reg = rg;
    nrise = 0; per_err = 0; hi_err = 0;
    bus_write(2'd1, (rd ? 32'h8000 : 32'h4000) | (32'(phy) << 5) | 32'(rg));
  endtask

  task automatic finish_frame();
    logic [31:0] r;
    logic [31:0] ew;
    int bad_pre, bad_frm;
    bus_read(2'd3, r);
    chk(r[0] == 1'b1, "R3 busy set during frame", r, 1);
    do bus_read(2'd3, r); while (r[0] == 1'b1);
    chk(nrise == pre_len + 32, "R6 MDC bit count", nrise, pre_len + 32);
    ew = {2'b01, (cur_rd ? 2'b10 : 2'b01), cur_phy, cur_reg, 2'b10, rd_val};
    bad_pre = 0; bad_frm = 0;
    for (int i = 0; i < pre_len + 32 && i < 64; i++) begin
      if (i < pre_len) begin
        if (!(cap_o[i] === 1'b1 && cap_oe[i] === 1'b1)) bad_pre++;
      end else begin
        int f;
        f = i - pre_len;
        if (cur_rd && f >= 14) begin
          if (cap_oe[i] !== 1'b0) bad_frm++;
        end else begin
          if (!(cap_oe[i] === 1'b1 && cap_o[i] === ew[31 - f])) bad_frm++;
        end
      end
    end
    chk(bad_pre == 0, "R6 preamble bits", bad_pre, 0);
    chk(bad_frm == 0, cur_rd ? "R8 read frame bits" : "R7 write frame bits", bad_frm, 0);
    chk(per_err == 0 && hi_err == 0, "R5 MDC period and high time", per_err + hi_err, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R5 MDC low and MDIO released when idle", {mdc, mdio_oe}, 0);
    if (cur_rd) begin
      bus_read(2'd2, r);
      chk(r == 32'(rd_val), "R8 read data in data register", r, rd_val);
    end
  endtask

  initial begin
    #(CLK_P * WD_CYC);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n0;
    idle(4);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    bus_read(2'd0, r); chk(r == (32'd39 << 9), "R1 control reset value", r, 32'd39 << 9);
    bus_read(2'd3, r); chk(r == 0, "R1 status reset value", r, 0);
    bus_read(2'd2, r); chk(r == 0, "R1 data reset value", r, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle after reset", {mdc, mdio_oe}, 0);

    // default divisor 40, write frame with preamble
    launch(1'b0, 39, 1'b0, 1'b0, 5'h11, 5'h0A, 16'hC3A5);
    finish_frame();

    // sweep divisors, opcodes, preamble, patterns
    for (int d = 0; d <= 6; d++) begin
      for (int p = 0; p < 2; p++) begin
        for (int o = 0; o < 2; o++) begin
          int k;
          logic [4:0] ph, rg;
          logic [15:0] v;
          k = d * 4 + p * 2 + o;
          ph = 5'(k * 7 + 3);
          rg = 5'(k * 11 + 1);
          v  = 16'hA5C3 ^ 16'(k * 16'h1357);
          if (k == 5)  begin ph = 5'h1F; rg = 5'h1F; v = 16'hFFFF; end
          if (k == 10) begin ph = 5'h00; rg = 5'h00; v = 16'h0000; end
          launch(1'b1, d, p[0], o[0], ph, rg, v);
          finish_frame();
        end
      end
    end

    // R4 command while busy is ignored
    launch(1'b1, 3, 1'b0, 1'b1, 5'd5, 5'd2, 16'h1234);
    idle(20);
    bus_write(2'd1, 32'h4000 | (32'd9 << 5) | 32'd7);
    finish_frame();
    bus_read(2'd1, r);
    chk(r == (32'h8000 | (32'd5 << 5) | 32'd2), "R4 command readback after busy write", r,
        32'h8000 | (32'd5 << 5) | 32'd2);
    n0 = nrise;
    idle(200);
    chk(nrise == n0, "R4 no second frame", nrise, n0);

    // R2 invalid op encodings
    nrise = 0;
    bus_write(2'd1, 32'hC000 | (32'd3 << 5) | 32'd4);
    bus_read(2'd3, r); chk(r == 0, "R2 both op bits start nothing", r, 0);
    bus_write(2'd1, (32'd3 << 5) | 32'd4);
    bus_read(2'd3, r); chk(r == 0, "R2 no op bit starts nothing", r, 0);
    idle(60);
    chk(nrise == 0, "R2 no MDC edges for invalid commands", nrise, 0);
    bus_read(2'd1, r);
    chk(r == (32'h8000 | (32'd5 << 5) | 32'd2), "R2 command readback unchanged", r,
        32'h8000 | (32'd5 << 5) | 32'd2);

    // R9 soft reset mid-frame
    launch(1'b1, 5, 1'b0, 1'b0, 5'd6, 5'd9, 16'hBEEF);
    idle(40);
    bus_write(2'd0, 32'h1);
    bus_read(2'd0, r); chk(r[0] == 1'b1, "R9 soft reset bit reads set", r, 1);
    bus_read(2'd3, r); chk(r == 0, "R9 frame aborted", r, 0);
    idle(6);
    bus_read(2'd0, r); chk(r == (32'd39 << 9), "R9 control restored and self-cleared", r, 32'd39 << 9);
    bus_read(2'd2, r); chk(r == 0, "R9 data cleared", r, 0);
    n0 = nrise;
    idle(100);
    chk(nrise == n0 && mdc == 1'b0, "R9 MDC stopped after soft reset", nrise, n0);

    // block still works after soft reset
    launch(1'b1, 2, 1'b1, 1'b1, 5'd21, 5'd13, 16'h5A0F);
    finish_frame();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule